// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the state of a single DDR SDRAM bank and decides, cycle by cycle, whether that bank may take a new activate. A memory controller feeds it the decoded command for the bank each cycle. It also feeds the auto-precharge address bit that goes with a read or a write, the programmed burst length, and the tRAS, tRP and tDAL timings expressed in clock cycles. In return it gets three plain status flags: activate permitted, precharge pending, and row open. A fourth, sticky flag reports any activate attempted while the bank could not take one.

A read that asks for auto precharge closes the row on its own. The internal precharge begins half a burst length of cycles after the read, or later if the row has not yet been open for tRAS cycles. The bank then becomes available tRP cycles after that start. A write that asks for auto precharge blocks the bank for tDAL cycles counted from the write command. A read or write without the bit leaves the row open. All inputs are control values sampled on the rising clock edge. There is no data stream and no handshake.

Top module: `bank_ap_tracker`

## Requirements
- R1: In an open bank, a read or write with `cmd_a10` low leaves the row open (`bank_open` stays 1) and `act_ok` stays 0.
- R2: An activate (`cmd`=1) sampled while `act_ok` is 1 makes `bank_open` 1 and `act_ok` 0 from the next cycle.
- R3: A read (`cmd`=2) with `cmd_a10` high at edge R, once tRAS is met, starts precharge at edge R+BL/2. A new activate is accepted at edge R+BL/2+tRP. Burst length comes from `bl_sel`: 0 selects 2, 1 selects 4, 2 or 3 selects 8.
- R4: If the activate was at edge A, precharge after a read with auto precharge starts at edge max(R+BL/2, A+tRAS). The next activate is accepted tRP edges after that start.
- R5: A write (`cmd`=3) with `cmd_a10` high at edge W makes the next activate acceptable at edge W+tDAL. Burst length has no effect on this. In between, `bank_open` is 0.
- R6: Between precharge start and the last cycle before the bank is free, `pre_busy` is 1, `bank_open` is 0 and `act_ok` is 0. Until the start, `bank_open` stays 1 and `pre_busy` 0.
- R7: An activate sampled while `act_ok` is 0 sets `proto_err`, which stays set until reset. The bank's state and timing are left unchanged.
- R8: After synchronous reset `act_ok` is 1, and `pre_busy`, `bank_open` and `proto_err` are 0.
- R9: A read or write to an idle bank is ignored: `act_ok` stays 1 and `bank_open` and `pre_busy` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 0 none, 1 activate, 2 read, 3 write |
| cmd_a10 | input | 1 | Auto-precharge request for read/write |
| bl_sel | input | 2 | Burst length select (0:2, 1:4, 2/3:8) |
| t_ras | input | CNT_W | Minimum activate-to-precharge cycles |
| t_rp | input | CNT_W | Precharge duration in cycles (0 treated as 1) |
| t_dal | input | CNT_W | Write-to-activate cycles (0 treated as 1) |
| act_ok | output | 1 | An activate this cycle is accepted |
| pre_busy | output | 1 | Precharge in progress |
| bank_open | output | 1 | Row is open |
| proto_err | output | 1 | Sticky illegal-activate flag |

## Verification
The bench builds the tracker with the default CNT_W of 6, so every timing fits a 6-bit field. The bench drives values between 1 and 20 to keep each scenario short. Because the timings are runtime inputs, this single build covers all three burst lengths and both read and write recovery. It also covers the case where tRAS outlasts half a burst and delays the precharge start by several cycles. Every scenario measures the exact edge at which an activate is first accepted.

// File: rtl/bap_pkg.sv
package bap_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } bap_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPEN = 3'd1,
    ST_WAIT = 3'd2,
    ST_RPRE = 3'd3,
    ST_WREC = 3'd4
  } bap_state_e;

  // half of the burst length: 0 -> 1, 1 -> 2, others -> 4
  function automatic logic [2:0] half_burst(input logic [1:0] sel);
    logic [3:0] bl;
    bl = (sel == 2'd3) ? 4'd8 : (4'd2 << sel);
    return 3'(bl >> 1);
  endfunction
endpackage

// File: rtl/bap_elapsed.sv
module bap_elapsed #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (restart)       count <= W'(1);
    else if (count != MAXV) count <= count + W'(1);
  end
endmodule

// File: rtl/bap_countdown.sv
module bap_countdown #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         done
);
  logic [W-1:0] val;

  always_ff @(posedge clk) begin
    if (rst)                        val <= '0;
    else if (load)                  val <= (load_val == '0) ? W'(1) : load_val;
    else if (dec && val > W'(1))    val <= val - W'(1);
  end

  assign done = (val == W'(1));
endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
  import bap_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  input  logic             cmd_a10,
  input  logic [1:0]       bl_sel,
  input  logic [CNT_W-1:0] t_ras,
  input  logic [CNT_W-1:0] t_rp,
  input  logic [CNT_W-1:0] t_dal,
  output logic             act_ok,
  output logic             pre_busy,
  output logic             bank_open,
  output logic             proto_err
);
  bap_state_e       st, st_nx;
  logic [CNT_W-1:0] since_act;
  logic             ras_ok, cd_done, cd_load, cd_dec, in_pre;
  logic [CNT_W-1:0] cd_val;
  logic             is_act, is_rd, is_wr;

  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);

  bap_elapsed #(.W(CNT_W)) u_ras (
    .clk(clk), .rst(rst), .restart(is_act && act_ok), .count(since_act)
  );

  bap_countdown #(.W(CNT_W)) u_cd (
    .clk(clk), .rst(rst), .load(cd_load), .load_val(cd_val),
    .dec(cd_dec), .done(cd_done)
  );

  assign ras_ok    = (since_act >= t_ras);
  assign in_pre    = (st == ST_RPRE) || (st == ST_WREC);
  assign act_ok    = (st == ST_IDLE) || (in_pre && cd_done);
  assign pre_busy  = in_pre && !cd_done;
  assign bank_open = (st == ST_OPEN) || (st == ST_WAIT);
  assign cd_dec    = (st == ST_WAIT) || in_pre;

  always_comb begin
    st_nx   = st;
    cd_load = 1'b0;
    cd_val  = '0;
    unique case (st)
      ST_IDLE: if (is_act) st_nx = ST_OPEN;
      ST_OPEN: begin
        if (is_rd && cmd_a10) begin
          st_nx   = ST_WAIT;
          cd_load = 1'b1;
          cd_val  = CNT_W'(half_burst(bl_sel));
        end else if (is_wr && cmd_a10) begin
          st_nx   = ST_WREC;
          cd_load = 1'b1;
          cd_val  = t_dal;
        end
      end
      ST_WAIT: if (cd_done && ras_ok) begin
        st_nx   = ST_RPRE;
        cd_load = 1'b1;
        cd_val  = t_rp;
      end
      ST_RPRE, ST_WREC: if (cd_done) st_nx = is_act ? ST_OPEN : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      proto_err <= 1'b0;
    end else begin
      st <= st_nx;
      if (is_act && !act_ok) proto_err <= 1'b1;
    end
  end
endmodule

// File: rtl/bap_checker.sv
module bap_checker
  import bap_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic             cmd_a10,
  input logic [CNT_W-1:0] t_ras,
  input logic [2:0]       st,
  input logic             act_ok,
  input logic             pre_busy,
  input logic             bank_open,
  input logic             proto_err
);
  logic [CNT_W-1:0] ce;

  always_ff @(posedge clk) begin
    if (rst)                              ce <= '0;
    else if (cmd == CMD_ACT && act_ok)    ce <= CNT_W'(1);
    else if (ce != {CNT_W{1'b1}})         ce <= ce + CNT_W'(1);
  end

  a_r1_noap_stays_open: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OPEN && (cmd == CMD_RD || cmd == CMD_WR) && !cmd_a10) |=> bank_open && !act_ok);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && act_ok) |=> bank_open && !act_ok);

  a_r4_ras_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && ce < t_ras) |=> bank_open && !pre_busy);

  a_r5_write_closes: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OPEN && cmd == CMD_WR && cmd_a10) |=> !bank_open);

  a_r7_err_on_bad_act: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && !act_ok) |=> proto_err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind bank_ap_tracker bap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cmd_a10(cmd_a10), .t_ras(t_ras),
  .st(st), .act_ok(act_ok), .pre_busy(pre_busy), .bank_open(bank_open),
  .proto_err(proto_err)
);

// File: tb/tb_bank_ap_tracker.sv
module tb_bank_ap_tracker;
  localparam int W = 6;
  logic         clk = 1'b0, rst = 1'b1;
  logic [1:0]   cmd = 2'd0, bl_sel = 2'd1;
  logic         cmd_a10 = 1'b0;
  logic [W-1:0] t_ras = W'(1), t_rp = W'(1), t_dal = W'(1);
  logic         act_ok, pre_busy, bank_open, proto_err;
  int           n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bank_ap_tracker #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_a10(cmd_a10), .bl_sel(bl_sel),
    .t_ras(t_ras), .t_rp(t_rp), .t_dal(t_dal), .act_ok(act_ok),
    .pre_busy(pre_busy), .bank_open(bank_open), .proto_err(proto_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; drives for one rising edge, returns at next negedge
  task automatic step(input logic [1:0] c, input logic a);
    cmd = c; cmd_a10 = a;
    @(posedge clk);
    @(negedge clk);
    cmd = 2'd0; cmd_a10 = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2'd0, 1'b0);
    step(2'd0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 act_ok", act_ok, 1);
    check("R8 pre_busy", pre_busy, 0);
    check("R8 bank_open", bank_open, 0);
    check("R8 proto_err", proto_err, 0);
  endtask

  task automatic t_idle_rw();
    do_reset();
    step(2'd2, 1'b1);
    step(2'd3, 1'b1);
    check("R9 act_ok", act_ok, 1);
    check("R9 bank_open", bank_open, 0);
    check("R9 pre_busy", pre_busy, 0);
  endtask

  task automatic t_open_noap();
    do_reset();
    t_ras = W'(2);
    step(2'd1, 1'b0);
    check("R2 bank_open", bank_open, 1);
    check("R2 act_ok", act_ok, 0);
    step(2'd2, 1'b0);
    step(2'd3, 1'b0);
    for (int i = 0; i < 8; i++) step(2'd0, 1'b0);
    check("R1 bank_open", bank_open, 1);
    check("R1 act_ok", act_ok, 0);
    check("R1 pre_busy", pre_busy, 0);
  endtask

  task automatic run_ap(input string tag, input bit wr, input logic [1:0] bsel,
                        input int tras, input int trp, input int tdal,
                        input int gap, input int bad_at, input int exp_lat);
    int lat;
    lat = -1;
    do_reset();
    bl_sel = bsel; t_ras = W'(tras); t_rp = W'(trp); t_dal = W'(tdal);
    step(2'd1, 1'b0);
    for (int i = 1; i < gap; i++) step(2'd0, 1'b0);
    step(wr ? 2'd3 : 2'd2, 1'b1);
    for (int k = 1; k <= 200; k++) begin
      if (act_ok) begin lat = k; break; end
      if (k == 1) begin
        if (wr) begin
          check({tag, " R5 open during recovery"}, bank_open, 0);
          check({tag, " R6 busy after write"}, pre_busy, 1);
        end else begin
          check({tag, " R6 open before start"}, bank_open, 1);
          check({tag, " R6 idle before start"}, pre_busy, 0);
        end
      end
      if (!wr && trp >= 2 && k == exp_lat - 1) begin
        check({tag, " R6 busy late"}, pre_busy, 1);
        check({tag, " R6 closed late"}, bank_open, 0);
      end
      step((k == bad_at) ? 2'd1 : 2'd0, 1'b0);
    end
    check({tag, " latency"}, lat, exp_lat);
    step(2'd1, 1'b0);
    check({tag, " R2 reopen"}, bank_open, 1);
    check({tag, " R7 err flag"}, proto_err, (bad_at > 0) ? 1 : 0);
  endtask

  task automatic t_sticky();
    run_ap("R7 bad act", 1'b0, 2'd1, 2, 4, 1, 20, 3, 6);
    for (int i = 0; i < 4; i++) step(2'd0, 1'b0);
    check("R7 sticky", proto_err, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_rw();
    t_open_noap();
    run_ap("R3 bl2", 1'b0, 2'd0, 2, 3, 1, 20, 0, 4);
    run_ap("R3 bl4", 1'b0, 2'd1, 2, 3, 1, 20, 0, 5);
    run_ap("R3 bl8", 1'b0, 2'd2, 2, 2, 1, 20, 0, 6);
    run_ap("R4 ras pending", 1'b0, 2'd1, 10, 3, 1, 1, 0, 12);
    run_ap("R4 ras just met", 1'b0, 2'd2, 8, 3, 1, 4, 0, 7);
    run_ap("R5 write bl4", 1'b1, 2'd1, 2, 3, 7, 10, 0, 7);
    run_ap("R5 write bl8", 1'b1, 2'd2, 2, 3, 7, 10, 0, 7);
    t_sticky();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule